// File: doc/BRIEF.md
# Condition Code Flag Unit

This block holds the 8-bit condition-code register of a processor datapath and keeps it current. An adder/subtractor beside it works on byte, word or longword operands. When the arithmetic flag update is enabled, the unit takes the two operands, the datapath result, the operation kind and the operand size. It then recomputes the half-carry, negative, zero, overflow and carry flags. The register can also be written directly, with a full load or a bitwise AND, OR or XOR against an 8-bit immediate. A strobe at the start of exception handling forces the interrupt mask on.

Every input is a single-cycle control strobe that is sampled on each clock. Nothing can stall, so the block has no valid/ready handshake and no back-pressure: an operation presented with its enable high takes effect at the next rising edge. The mask output feeds the interrupt logic, which blocks maskable requests while the mask is 1. The non-maskable request is routed around this output and never uses it.

Top module: `ccr_flag_unit`

## Requirements
- R1: During and after reset, register bit 7 (interrupt mask) is 1, and `irq_mask_o` equals bit 7 at all times. The other seven bits have no defined reset value.
- R2: When `exc_entry_i` is high, bit 7 becomes 1 at the next edge and bits 6..0 keep their value. This holds even if register or arithmetic operations are requested in the same cycle.
- R3: When `reg_en_i` is high and `exc_entry_i` is low, the register is updated from `reg_imm_i` according to `reg_cmd_i`: 0 loads the immediate, 1 ANDs it in, 2 ORs it in and 3 XORs it in. A register operation overrides an arithmetic update in the same cycle.
- R4: An arithmetic update leaves bits 7, 6 and 4 unchanged. The field layout from bit 7 down is mask, user bit, H, user bit, N, Z, V, C.
- R5: On an arithmetic update, H (bit 5) is the carry (for additions) or borrow (for subtract, compare and negate) out of bit 3 for bytes, bit 11 for words and bit 27 for longwords.
- R6: N (bit 3) takes the result's top bit at the active size: bit 7, 15 or 31.
- R7: For add, subtract, compare and negate, Z (bit 2) is 1 exactly when the result masked to the active size is zero.
- R8: For add-with-extend and subtract-with-extend, Z is cleared when the masked result is non-zero and otherwise keeps its previous value.
- R9: V (bit 1) is 1 exactly when the operation overflows as a two's-complement signed operation at the active size.
- R10: C (bit 0) is the carry out of the top bit for additions and the borrow for subtract, compare and negate. The extend operations use the previous C as carry-in or borrow-in.
- R11: The operation codes are add 0, add-with-extend 1, subtract 2, subtract-with-extend 3, compare 4 and negate 5. Compare sets flags exactly as subtract does (a minus b). Negate sets flags as 0 minus `opnd_b_i`. The size codes are 0 byte, 1 word and 2 or 3 longword.
- R12: In a cycle with no exception, no register operation and no arithmetic enable, the register holds its value. Operand bits above the active size have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_entry_i | input | 1 | Start of exception handling; forces the mask |
| reg_en_i | input | 1 | Apply a register operation this cycle |
| reg_cmd_i | input | 2 | Register operation: load, AND, OR, XOR |
| reg_imm_i | input | 8 | Immediate for the register operation |
| arith_en_i | input | 1 | Update arithmetic flags this cycle |
| arith_op_i | input | 3 | Arithmetic operation kind |
| arith_size_i | input | 2 | Operand size |
| opnd_a_i | input | 32 | First operand (minuend for subtraction) |
| opnd_b_i | input | 32 | Second operand (subtrahend, or negate input) |
| result_i | input | 32 | Datapath result for the operation |
| ccr_o | output | 8 | Register value |
| irq_mask_o | output | 1 | Mask that qualifies maskable interrupts |

## Verification
The byte sweep covers every minuend against a spread of second operands that includes 0x00, 0x80 and 0xFF. It runs each of the six operations with preloaded C and Z values that vary, which separates carry from borrow, shows the extend carry-in and shows Z stickiness. Word and longword runs use pseudo-random operands plus signed and unsigned boundary values. These runs tell the 11 and 27 half-carry taps from the byte tap and confirm that V is separate from C. Garbage placed above the active size shows the masking. Directed cycles then set exception, register and arithmetic requests against each other to expose the priority order and the hold behaviour.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDX = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBX = 3'd3,
    OP_CMP  = 3'd4,
    OP_NEG  = 3'd5
  } arith_op_e;

  typedef enum logic [1:0] {
    RC_LOAD = 2'd0,
    RC_AND  = 2'd1,
    RC_OR   = 2'd2,
    RC_XOR  = 2'd3
  } reg_cmd_e;

  localparam int CCR_W  = 8;
  localparam int BIT_I  = 7;
  localparam int BIT_UI = 6;
  localparam int BIT_H  = 5;
  localparam int BIT_U  = 4;
  localparam int BIT_N  = 3;
  localparam int BIT_Z  = 2;
  localparam int BIT_V  = 1;
  localparam int BIT_C  = 0;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/ccr_size_flags.sv
module ccr_size_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] res_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic         h_o,
  output logic         n_o,
  output logic         zero_o,
  output logic         v_o,
  output logic         c_o
);
  localparam int HB = W - 4;

  logic [HB:0] lo_sum;
  logic [W-1:0] top_sum;
  logic [W:0] full_sum;

  // Each partial sum exposes its carry (or borrow, via wrap) in its top bit.
  always_comb begin
    if (sub_i) begin
      lo_sum   = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, cin_i};
      top_sum  = {1'b0, a_i[W-2:0]} - {1'b0, b_i[W-2:0]} - {{(W-1){1'b0}}, cin_i};
      full_sum = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    end else begin
      lo_sum   = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
      top_sum  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
      full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end
  end

  assign h_o    = lo_sum[HB];
  assign c_o    = full_sum[W];
  assign v_o    = full_sum[W] ^ top_sum[W-1];
  assign n_o    = res_i[W-1];
  assign zero_o = ~|res_i;
endmodule

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          c_prev_i,
  input  logic          z_prev_i,
  output arith_flags_t  flags_o
);
  localparam int NSZ    = 3;
  localparam int BYTE_W = DW / 4;

  logic is_sub, is_ext, cin;
  logic [DW-1:0] a_eff;
  logic [NSZ-1:0] h_s, n_s, z_s, v_s, c_s;

  always_comb begin
    is_ext = (op_i == OP_ADDX) || (op_i == OP_SUBX);
    is_sub = (op_i == OP_SUB) || (op_i == OP_SUBX) || (op_i == OP_CMP) || (op_i == OP_NEG);
    cin    = is_ext & c_prev_i;
    a_eff  = (op_i == OP_NEG) ? '0 : a_i;
  end

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int W = BYTE_W << s;
    ccr_size_flags #(.W(W)) u_flags (
      .a_i   (a_eff[W-1:0]),
      .b_i   (b_i[W-1:0]),
      .res_i (res_i[W-1:0]),
      .cin_i (cin),
      .sub_i (is_sub),
      .h_o   (h_s[s]),
      .n_o   (n_s[s]),
      .zero_o(z_s[s]),
      .v_o   (v_s[s]),
      .c_o   (c_s[s])
    );
  end

  logic [1:0] sel;
  assign sel = (size_i == 2'd3) ? 2'd2 : size_i;

  always_comb begin
    flags_o.h = h_s[sel];
    flags_o.n = n_s[sel];
    flags_o.v = v_s[sel];
    flags_o.c = c_s[sel];
    flags_o.z = is_ext ? (z_prev_i & z_s[sel]) : z_s[sel];
  end
endmodule

// File: rtl/ccr_reg_logic.sv
module ccr_reg_logic
  import ccr_pkg::*;
(
  input  logic [1:0]       cmd_i,
  input  logic [CCR_W-1:0] imm_i,
  input  logic [CCR_W-1:0] cur_i,
  output logic [CCR_W-1:0] nxt_o
);
  always_comb begin
    unique case (reg_cmd_e'(cmd_i))
      RC_LOAD: nxt_o = imm_i;
      RC_AND:  nxt_o = cur_i & imm_i;
      RC_OR:   nxt_o = cur_i | imm_i;
      default: nxt_o = cur_i ^ imm_i;
    endcase
  end
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_entry_i,
  input  logic          reg_en_i,
  input  logic [1:0]    reg_cmd_i,
  input  logic [7:0]    reg_imm_i,
  input  logic          arith_en_i,
  input  logic [2:0]    arith_op_i,
  input  logic [1:0]    arith_size_i,
  input  logic [DW-1:0] opnd_a_i,
  input  logic [DW-1:0] opnd_b_i,
  input  logic [DW-1:0] result_i,
  output logic [7:0]    ccr_o,
  output logic          irq_mask_o
);
  logic          mask_q;
  logic [BIT_I-1:0] low_q;
  logic [CCR_W-1:0] ccr_cur, reg_nxt, arith_nxt, ccr_nxt;
  arith_flags_t  af;

  assign ccr_cur = {mask_q, low_q};

  ccr_reg_logic u_reg (
    .cmd_i(reg_cmd_i),
    .imm_i(reg_imm_i),
    .cur_i(ccr_cur),
    .nxt_o(reg_nxt)
  );

  ccr_arith_flags #(.DW(DW)) u_arith (
    .op_i    (arith_op_i),
    .size_i  (arith_size_i),
    .a_i     (opnd_a_i),
    .b_i     (opnd_b_i),
    .res_i   (result_i),
    .c_prev_i(ccr_cur[BIT_C]),
    .z_prev_i(ccr_cur[BIT_Z]),
    .flags_o (af)
  );

  always_comb begin
    arith_nxt = ccr_cur;
    arith_nxt[BIT_H] = af.h;
    arith_nxt[BIT_N] = af.n;
    arith_nxt[BIT_Z] = af.z;
    arith_nxt[BIT_V] = af.v;
    arith_nxt[BIT_C] = af.c;

    if (exc_entry_i)     ccr_nxt = ccr_cur | (CCR_W'(1) << BIT_I);
    else if (reg_en_i)   ccr_nxt = reg_nxt;
    else if (arith_en_i) ccr_nxt = arith_nxt;
    else                 ccr_nxt = ccr_cur;
  end

  // Only the mask has a defined reset value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b1;
    else        mask_q <= ccr_nxt[BIT_I];
  end

  always_ff @(posedge clk) begin
    low_q <= ccr_nxt[BIT_I-1:0];
  end

  assign ccr_o      = ccr_cur;
  assign irq_mask_o = mask_q;

  a_r2_exc_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry_i |=> (ccr_o[BIT_I] && ccr_o[BIT_I-1:0] == $past(ccr_o[BIT_I-1:0])));

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_entry_i && reg_en_i && reg_cmd_i == 2'd0) |=> (ccr_o == $past(reg_imm_i)));

  a_r4_user_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_entry_i && !reg_en_i) |=>
      ($stable(ccr_o[BIT_I]) && $stable(ccr_o[BIT_UI]) && $stable(ccr_o[BIT_U])));

  a_r8_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_entry_i && !reg_en_i && arith_en_i && !ccr_o[BIT_Z] &&
     (arith_op_i == 3'd1 || arith_op_i == 3'd3)) |=> !ccr_o[BIT_Z]);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_entry_i && !reg_en_i && !arith_en_i) |=> $stable(ccr_o));

  a_r1_mask_tracks: assert property (@(posedge clk) irq_mask_o == ccr_o[BIT_I]);
endmodule

// File: tb/tb_ccr_flag_unit.sv
module tb_ccr_flag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_entry_i = 1'b0, reg_en_i = 1'b0, arith_en_i = 1'b0;
  logic [1:0] reg_cmd_i = '0, arith_size_i = '0;
  logic [7:0] reg_imm_i = '0;
  logic [2:0] arith_op_i = '0;
  logic [31:0] opnd_a_i = '0, opnd_b_i = '0, result_i = '0;
  logic [7:0] ccr_o;
  logic irq_mask_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  ccr_flag_unit dut (.*);

  function automatic logic [31:0] rnd(inout logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Reference flags from plain integer arithmetic (R5..R11).
  function automatic logic [7:0] model(input int op, input int sz, input longint a_in,
                                       input longint b_in, input logic [7:0] pre,
                                       output longint res);
    int w = (sz >= 2) ? 32 : (8 << sz);
    longint m = (64'sd1 <<< w) - 1;
    longint hm = (64'sd1 <<< (w - 4)) - 1;
    longint half = 64'sd1 <<< (w - 1);
    bit ext = (op == 1 || op == 3);
    bit sub = (op >= 2);
    longint cin = ext ? longint'(pre[0]) : 0;
    longint aa = (op == 5) ? 0 : (a_in & m);
    longint bb = b_in & m;
    longint sa = (aa >= half) ? aa - (64'sd1 <<< w) : aa;
    longint sb = (bb >= half) ? bb - (64'sd1 <<< w) : bb;
    longint sr;
    bit h, c, v, n, z;
    if (sub) begin
      res = (aa - bb - cin) & m;
      c = (aa < bb + cin);
      h = ((aa & hm) < (bb & hm) + cin);
      sr = sa - sb - cin;
    end else begin
      res = (aa + bb + cin) & m;
      c = ((aa + bb + cin) >> w) & 1;
      h = (((aa & hm) + (bb & hm) + cin) >> (w - 4)) & 1;
      sr = sa + sb + cin;
    end
    v = (sr >= half) || (sr < -half);
    n = (res >> (w - 1)) & 1;
    z = ext ? (pre[2] && res == 0) : (res == 0);
    return {pre[7], pre[6], h, pre[4], n, z, v, c};
  endfunction

  function automatic string flag_tag(input logic [7:0] act, input logic [7:0] exp, input int op);
    logic [7:0] d = act ^ exp;
    if (d[5]) return "R5 half-carry";
    if (d[3]) return "R6 negative";
    if (d[2]) return (op == 1 || op == 3) ? "R8 sticky zero" : "R7 zero";
    if (d[1]) return "R9 overflow";
    if (d[0]) return (op >= 4) ? "R11 cmp/neg carry" : "R10 carry";
    return "R4 untouched bits";
  endfunction

  // Called at a falling edge; preloads the register then applies one arithmetic update.
  task automatic run_vec(input int op, input int sz, input logic [31:0] a,
                         input logic [31:0] b, input logic [7:0] pre, input logic [31:0] junk);
    longint r;
    logic [7:0] exp;
    int w = (sz >= 2) ? 32 : (8 << sz);
    logic [31:0] hi = (w == 32) ? 32'h0 : (junk << w);
    exp = model(op, sz, longint'(a), longint'(b), pre, r);
    reg_en_i = 1'b1; reg_cmd_i = 2'd0; reg_imm_i = pre;
    @(negedge clk);
    reg_en_i = 1'b0; arith_en_i = 1'b1;
    arith_op_i = 3'(op); arith_size_i = 2'(sz);
    opnd_a_i = a | hi; opnd_b_i = b | hi; result_i = 32'(r) | hi;
    @(negedge clk);
    arith_en_i = 1'b0;
    if (ccr_o !== exp) begin
      n_checks++; n_fail++;
      $display("FAIL %s op=%0d sz=%0d a=%08h b=%08h actual=%02h expected=%02h",
               flag_tag(ccr_o, exp, op), op, sz, a, b, ccr_o, exp);
    end else n_checks++;
  endtask

  function automatic logic [31:0] corner(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return 32'h0FFF_FFFF;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    check("R1 mask in reset", {7'b0, irq_mask_o}, 8'h01);
    check("R1 bit7 in reset", {7'b0, ccr_o[7]}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mask after reset", {7'b0, ccr_o[7] & irq_mask_o}, 8'h01);

    // R3: every immediate under each register operation.
    for (int i = 0; i < 256; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [7:0] base = 8'(i * 37 + 11);
        reg_en_i = 1'b1; reg_cmd_i = 2'd0; reg_imm_i = base;
        @(negedge clk);
        reg_cmd_i = 2'(c); reg_imm_i = 8'(i);
        arith_en_i = 1'b1; arith_op_i = 3'd0; arith_size_i = 2'd0;
        opnd_a_i = 32'hFF; opnd_b_i = 32'h1; result_i = 32'h0;
        @(negedge clk);
        reg_en_i = 1'b0; arith_en_i = 1'b0;
        case (c)
          0: exp = 8'(i);
          1: exp = base & 8'(i);
          2: exp = base | 8'(i);
          default: exp = base ^ 8'(i);
        endcase
        check("R3 register op", ccr_o, exp);
        check("R1 mask output", {7'b0, irq_mask_o}, {7'b0, exp[7]});
      end
    end

    // R2: exception beats register and arithmetic requests.
    reg_en_i = 1'b1; reg_cmd_i = 2'd0; reg_imm_i = 8'h35;
    @(negedge clk);
    exc_entry_i = 1'b1; reg_cmd_i = 2'd0; reg_imm_i = 8'h00; arith_en_i = 1'b1;
    @(negedge clk);
    exc_entry_i = 1'b0; reg_en_i = 1'b0; arith_en_i = 1'b0;
    check("R2 exception priority", ccr_o, 8'hB5);

    // R12: idle cycles and disabled arithmetic hold the register.
    opnd_a_i = 32'h80; opnd_b_i = 32'h80; result_i = 32'h0;
    repeat (3) @(negedge clk);
    check("R12 hold", ccr_o, 8'hB5);

    // Byte sweep: every first operand, spread of second operands, all operations.
    for (int a = 0; a < 256; a++)
      for (int bi = 0; bi < 17; bi++)
        for (int op = 0; op < 6; op++) begin
          logic [31:0] b = (bi == 16) ? 32'h80 : 32'(bi * 17);
          run_vec(op, 0, 32'(a), b, 8'(a * 7 + bi * 13 + op), rnd(seed));
        end

    // Word and longword: corners then pseudo-random.
    for (int sz = 1; sz < 4; sz++) begin
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int op = 0; op < 6; op++)
            run_vec(op, sz, corner(i), corner(j), 8'(i * 5 + j * 3 + op), rnd(seed));
      for (int k = 0; k < 1200; k++) begin
        logic [31:0] a = rnd(seed);
        logic [31:0] b = rnd(seed);
        run_vec(k % 6, sz, a, b, rnd(seed)[7:0], rnd(seed));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule